// File: doc/BRIEF.md
# Position-Locked Block Averager

This block recovers detail that lies below one LSB of a converter path by averaging many captures of the same periodic test block. Each incoming signed sample is added to an accumulator chosen by the sample's position inside the current block, so position k of one block is only ever combined with position k of the others. Noise that is uncorrelated from block to block shrinks roughly by the square root of the block count: about 173 times, or 45 dB, at 30,000 blocks. A deterministic pattern keeps its full size.

A run begins with a one-cycle `start` pulse. This latches the block length and the block count, then sweeps the accumulator store to zero. After the sweep, a sample that carries the block marker opens a block at position 0. Each following valid sample takes the next position, until the last position closes the block. When the programmed number of blocks has closed, the block divides every accumulator by the count. It rounds toward negative infinity and streams the averages out in position order. It then raises `done` and holds it there until the next `start`.

Top module: `blkavg_top`

## Requirements
- R1: After reset, `out_valid` and `done` are low and stay low until a run completes.
- R2: Position k is the number of samples accepted since the last block marker. Output word k equals the average, over all programmed blocks, of the samples accepted at position k.
- R3: Each average is the signed sum divided by the block count, rounded toward negative infinity. For example, a sum of -7 over 5 blocks gives -2, and a sum of 7 over 5 blocks gives 1.
- R4: The following valid samples are ignored: those before the first marker of a run, those after a block's last position and before the next marker, and those that arrive during the clearing sweep.
- R5: Block counts up to 30,000 with full-scale samples (-8388608 and 8388607) give exact averages, with no accumulator overflow.
- R6: A `start` pulse discards all sums from the previous run, so a new run's averages depend only on its own samples.
- R7: Averages appear once per position, with `out_valid` high and `out_index` counting 0 up to length-1. Then `done` rises and holds until the next `start`.
- R8: Cycles with `in_valid` low neither advance the position nor change any sum.
- R9: A block length of 1 is supported; every marked sample then forms a complete block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: latch configuration, clear sums, arm a new run |
| cfg_len | input | 12 | Block length in samples, 1 to 2048 (0 is taken as 1) |
| cfg_blocks | input | 15 | Number of blocks to average (0 is taken as 1) |
| in_valid | input | 1 | Sample present this cycle |
| in_sof | input | 1 | Block marker, meaningful only with `in_valid` |
| in_sample | input | 24 | Signed two's-complement sample |
| out_valid | output | 1 | Averaged word present |
| out_index | output | 11 | Position of the averaged word |
| out_avg | output | 24 | Signed floor average |
| done | output | 1 | All averages delivered for this run |

## Verification
The hardest case to reach is a long run at full scale: 30,000 blocks whose samples sit at the most negative and most positive codes. Only this run drives the accumulators near their width limit and produces the largest dividend magnitudes. The bench reaches it with a 2-position block fed back to back for about 60,000 cycles. The rounding case, negative sums that do not divide evenly, needs small values clustered around zero. A directed run draws samples from a narrow band biased below zero, and random full-range runs with junk samples and idle gaps cover the ignore rules.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_READ,
    ST_DONE
  } avg_state_e;

endpackage

// File: rtl/blkavg_ctrl.sv
module blkavg_ctrl
  import blkavg_pkg::*;
#(
  parameter int MAX_LEN    = 2048,
  parameter int MAX_BLOCKS = 32767
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [$clog2(MAX_LEN):0]        cfg_len,
  input  logic [$clog2(MAX_BLOCKS+1)-1:0] cfg_blocks,
  input  logic                            in_valid,
  input  logic                            in_sof,
  input  logic                            div_valid,
  output avg_state_e                      state,
  output logic [$clog2(MAX_LEN):0]        len_q,
  output logic [$clog2(MAX_BLOCKS+1)-1:0] blocks_q,
  output logic [$clog2(MAX_BLOCKS+1)-1:0] blk_cnt,
  output logic                            clr_we,
  output logic [$clog2(MAX_LEN):0]        clr_idx,
  output logic                            acc_we,
  output logic [$clog2(MAX_LEN):0]        acc_idx,
  output logic [$clog2(MAX_LEN):0]        rd_idx,
  output logic                            rd_go,
  output logic                            done
);

  localparam int LEN_W = $clog2(MAX_LEN) + 1;
  localparam int CNT_W = $clog2(MAX_BLOCKS + 1);

  logic [LEN_W-1:0] pos;
  logic             in_blk;
  logic [LEN_W-1:0] len_eff;
  logic [CNT_W-1:0] blocks_eff;
  logic             take;
  logic             last_pos;
  logic             last_blk;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v == '0)                  return LEN_W'(1);
    else if (v > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    else                          return v;
  endfunction

  always_comb begin
    len_eff    = clamp_len(cfg_len);
    blocks_eff = (cfg_blocks == '0) ? CNT_W'(1) : cfg_blocks;
    take       = (state == ST_COLLECT) && in_valid && (in_sof || in_blk);
    acc_idx    = in_sof ? '0 : pos;
    last_pos   = (acc_idx == len_q - LEN_W'(1));
    last_blk   = ((blk_cnt + CNT_W'(1)) == blocks_q);
    acc_we     = take;
    clr_we     = (state == ST_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      blocks_q <= '0;
      blk_cnt  <= '0;
      clr_idx  <= '0;
      pos      <= '0;
      in_blk   <= 1'b0;
      rd_idx   <= '0;
      rd_go    <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      state    <= ST_CLEAR;
      len_q    <= len_eff;
      blocks_q <= blocks_eff;
      blk_cnt  <= '0;
      clr_idx  <= '0;
      pos      <= '0;
      in_blk   <= 1'b0;
      rd_idx   <= '0;
      rd_go    <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_go <= 1'b0;
      unique case (state)
        ST_CLEAR: begin
          if (clr_idx == len_q - LEN_W'(1)) state <= ST_COLLECT;
          else clr_idx <= clr_idx + LEN_W'(1);
        end
        ST_COLLECT: begin
          if (take) begin
            if (last_pos) begin
              in_blk  <= 1'b0;
              pos     <= '0;
              blk_cnt <= blk_cnt + CNT_W'(1);
              if (last_blk) begin
                state  <= ST_READ;
                rd_idx <= '0;
                rd_go  <= 1'b1;
              end
            end else begin
              in_blk <= 1'b1;
              pos    <= acc_idx + LEN_W'(1);
            end
          end
        end
        ST_READ: begin
          if (div_valid) begin
            if (rd_idx == len_q - LEN_W'(1)) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              rd_idx <= rd_idx + LEN_W'(1);
              rd_go  <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blkavg_accmem.sv
module blkavg_accmem #(
  parameter int SAMPLE_W = 24,
  parameter int ACC_W    = 40,
  parameter int DEPTH    = 2048
) (
  input  logic                     clk,
  input  logic                     clr_we,
  input  logic [$clog2(DEPTH)-1:0] clr_idx,
  input  logic                     acc_we,
  input  logic [$clog2(DEPTH)-1:0] acc_idx,
  input  logic [SAMPLE_W-1:0]      acc_sample,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ACC_W-1:0]         acc_old,
  output logic [ACC_W-1:0]         acc_new,
  output logic [ACC_W-1:0]         rd_data
);

  logic [ACC_W-1:0] mem [DEPTH];

  function automatic logic [ACC_W-1:0] widen(input logic [SAMPLE_W-1:0] s);
    return {{(ACC_W - SAMPLE_W){s[SAMPLE_W-1]}}, s};
  endfunction

  always_comb begin
    acc_old = mem[acc_idx];
    acc_new = acc_old + widen(acc_sample);
    rd_data = mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (clr_we)      mem[clr_idx] <= '0;
    else if (acc_we) mem[acc_idx] <= acc_new;
  end

endmodule

// File: rtl/blkavg_floordiv.sv
module blkavg_floordiv #(
  parameter int ACC_W = 40,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [ACC_W-1:0] dividend,
  input  logic [CNT_W-1:0] divisor,
  output logic             busy,
  output logic             valid,
  output logic [ACC_W-1:0] q_full
);

  localparam int STEP_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]  quo;
  logic [CNT_W:0]    rem;
  logic [CNT_W-1:0]  dvs;
  logic              neg;
  logic [STEP_W-1:0] step;
  logic [ACC_W-1:0]  mag;
  logic [CNT_W:0]    sh;
  logic              fits;

  function automatic logic [ACC_W-1:0] floor_fix(input logic n,
                                                 input logic [ACC_W-1:0] q,
                                                 input logic rem_nz);
    if (!n)        return q;
    else if (rem_nz) return ~q;
    else           return ~q + ACC_W'(1);
  endfunction

  always_comb begin
    mag    = dividend[ACC_W-1] ? (~dividend + ACC_W'(1)) : dividend;
    sh     = {rem[CNT_W-1:0], quo[ACC_W-1]};
    fits   = (sh >= {1'b0, dvs});
    q_full = floor_fix(neg, quo, rem != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo   <= '0;
      rem   <= '0;
      dvs   <= '0;
      neg   <= 1'b0;
      step  <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        quo  <= mag;
        rem  <= '0;
        dvs  <= divisor;
        neg  <= dividend[ACC_W-1];
        step <= STEP_W'(ACC_W);
        busy <= 1'b1;
      end else if (busy) begin
        quo  <= {quo[ACC_W-2:0], fits};
        rem  <= fits ? (sh - {1'b0, dvs}) : sh;
        step <= step - STEP_W'(1);
        if (step == STEP_W'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blkavg_top.sv
module blkavg_top
  import blkavg_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int MAX_LEN    = 2048,
  parameter int MAX_BLOCKS = 32767
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [$clog2(MAX_LEN):0]        cfg_len,
  input  logic [$clog2(MAX_BLOCKS+1)-1:0] cfg_blocks,
  input  logic                            in_valid,
  input  logic                            in_sof,
  input  logic [SAMPLE_W-1:0]             in_sample,
  output logic                            out_valid,
  output logic [$clog2(MAX_LEN)-1:0]      out_index,
  output logic [SAMPLE_W-1:0]             out_avg,
  output logic                            done
);

  localparam int IDX_W = $clog2(MAX_LEN);
  localparam int LEN_W = IDX_W + 1;
  localparam int CNT_W = $clog2(MAX_BLOCKS + 1);
  localparam int ACC_W = SAMPLE_W + CNT_W + 1;

  avg_state_e       state;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] blocks_q;
  logic [CNT_W-1:0] blk_cnt;
  logic             clr_we;
  logic [LEN_W-1:0] clr_idx;
  logic             acc_we;
  logic [LEN_W-1:0] acc_idx;
  logic [LEN_W-1:0] rd_idx;
  logic             rd_go;
  logic [ACC_W-1:0] acc_old;
  logic [ACC_W-1:0] acc_new;
  logic [ACC_W-1:0] rd_data;
  logic             div_busy;
  logic             div_valid;
  logic [ACC_W-1:0] div_full;

  blkavg_ctrl #(.MAX_LEN(MAX_LEN), .MAX_BLOCKS(MAX_BLOCKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_len(cfg_len), .cfg_blocks(cfg_blocks),
    .in_valid(in_valid), .in_sof(in_sof), .div_valid(div_valid),
    .state(state), .len_q(len_q), .blocks_q(blocks_q), .blk_cnt(blk_cnt),
    .clr_we(clr_we), .clr_idx(clr_idx), .acc_we(acc_we), .acc_idx(acc_idx),
    .rd_idx(rd_idx), .rd_go(rd_go), .done(done)
  );

  blkavg_accmem #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DEPTH(MAX_LEN)) u_mem (
    .clk(clk),
    .clr_we(clr_we), .clr_idx(clr_idx[IDX_W-1:0]),
    .acc_we(acc_we), .acc_idx(acc_idx[IDX_W-1:0]), .acc_sample(in_sample),
    .rd_idx(rd_idx[IDX_W-1:0]),
    .acc_old(acc_old), .acc_new(acc_new), .rd_data(rd_data)
  );

  blkavg_floordiv #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(rd_go),
    .dividend(rd_data), .divisor(blocks_q),
    .busy(div_busy), .valid(div_valid), .q_full(div_full)
  );

  always_comb begin
    out_valid = div_valid && (state == ST_READ);
    out_index = rd_idx[IDX_W-1:0];
    out_avg   = div_full[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/blkavg_chk.sv
module blkavg_chk #(
  parameter int SAMPLE_W = 24,
  parameter int LEN_W    = 12,
  parameter int CNT_W    = 15,
  parameter int ACC_W    = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                out_valid,
  input logic [LEN_W-2:0]    out_index,
  input logic                done,
  input logic [LEN_W-1:0]    len_q,
  input logic [CNT_W-1:0]    blocks_q,
  input logic [CNT_W-1:0]    blk_cnt,
  input logic                acc_we,
  input logic [ACC_W-1:0]    acc_old,
  input logic [ACC_W-1:0]    acc_new,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                div_busy,
  input logic [ACC_W-1:0]    div_full
);

  logic [LEN_W-1:0] ocount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ocount <= '0;
    else if (start)     ocount <= '0;
    else if (out_valid) ocount <= ocount + LEN_W'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we && (acc_old[ACC_W-1] == in_sample[SAMPLE_W-1]) |-> acc_new[ACC_W-1] == acc_old[ACC_W-1]); // R5
  AST_BLOCKS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt <= blocks_q); // R5
  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> {1'b0, out_index} == ocount); // R7
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> {1'b0, out_index} < len_q); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R7
  AST_AVG_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((&div_full[ACC_W-1:SAMPLE_W-1]) || (~|div_full[ACC_W-1:SAMPLE_W-1]))); // R3
  AST_NO_OUT_DURING_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> !out_valid && !div_busy); // R2

endmodule

bind blkavg_top blkavg_chk #(
  .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_index(out_index), .done(done), .len_q(len_q), .blocks_q(blocks_q),
  .blk_cnt(blk_cnt), .acc_we(acc_we), .acc_old(acc_old), .acc_new(acc_new),
  .in_sample(in_sample), .div_busy(div_busy), .div_full(div_full)
);

// File: tb/test_blkavg_top.sv
module test_blkavg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] cfg_len = '0;
  logic [14:0] cfg_blocks = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [23:0] in_sample = '0;
  logic        out_valid;
  logic [10:0] out_index;
  logic [23:0] out_avg;
  logic        done;

  int     n_checks = 0;
  int     n_errors = 0;
  bit     finished = 1'b0;
  longint model [2048];

  always #5 clk = ~clk;

  blkavg_top i_blkavg_top (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_blocks(cfg_blocks), .in_valid(in_valid), .in_sof(in_sof),
    .in_sample(in_sample), .out_valid(out_valid), .out_index(out_index),
    .out_avg(out_avg), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // floor average restated: truncating quotient stepped down when negative and inexact
  function automatic longint floor_avg(input longint s, input longint c);
    longint q = s / c;
    if ((s % c) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  function automatic int gen(input int kind, input int k);
    int r = int'($urandom);
    case (kind)
      0:       return {{8{r[23]}}, r[23:0]};
      1:       return -3 + int'($urandom % 5);
      2:       return (k == 0) ? -8388608 : 8388607;
      default: return k * 1000 - 500 + int'($urandom % 7);
    endcase
  endfunction

  task automatic begin_run(input int len, input int nblk);
    @(negedge clk);
    cfg_len = 12'(len); cfg_blocks = 15'(nblk); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2048; i++) model[i] = 0;
  endtask

  task automatic drive(input bit v, input bit sof, input int s);
    in_valid = v; in_sof = sof; in_sample = s[23:0];
    @(negedge clk);
  endtask

  // junk: 1 = ignored samples before the first marker, during clear and between blocks
  task automatic feed(input int len, input int nblk, input int kind, input bit junk, input bit gaps);
    if (junk) begin
      for (int j = 0; j < len + 3; j++) drive(1'b1, (j == 1), 24'h7FFFFF);
    end else begin
      repeat (len + 1) drive(1'b0, 1'b0, 0);
    end
    for (int b = 0; b < nblk; b++) begin
      if (junk && b > 0) begin
        for (int j = 0; j < 3; j++) drive(1'b1, 1'b0, -8000000);
      end
      for (int k = 0; k < len; k++) begin
        int s = gen(kind, k);
        if (gaps && ($urandom % 4 == 0)) drive(1'b0, 1'b1, 12345);
        model[k] += longint'(s);
        drive(1'b1, (k == 0), s);
      end
    end
    drive(1'b0, 1'b0, 0);
  endtask

  task automatic collect(input int len, input int nblk, input string req);
    int got = 0;
    int waited = 0;
    while (got < len && waited < 100000) begin
      if (out_valid) begin
        chk(out_index == 11'(got), "R7", longint'(out_index), longint'(got));
        chk($signed(out_avg) == floor_avg(model[got], nblk), req,
            longint'($signed(out_avg)), floor_avg(model[got], nblk));
        got++;
      end
      @(negedge clk);
      waited++;
    end
    chk(got == len, "R7", got, len);
    @(negedge clk);
    chk(done == 1'b1, "R7", longint'(done), 1);
    repeat (5) @(negedge clk);
    chk(done == 1'b1 && out_valid == 1'b0, "R7", longint'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1", longint'({out_valid, done}), 0);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1", longint'({out_valid, done}), 0);

    // R2 R8: random full-range samples with idle gaps
    begin_run(8, 5);
    feed(8, 5, 0, 1'b0, 1'b1);
    collect(8, 5, "R2");

    // R3: small values biased below zero, inexact negative sums
    begin_run(6, 7);
    feed(6, 7, 1, 1'b0, 1'b0);
    collect(6, 7, "R3");

    // R4: junk before the first marker, during the clear sweep and between blocks
    begin_run(5, 4);
    feed(5, 4, 3, 1'b1, 1'b1);
    collect(5, 4, "R4");

    // R5: 30000 blocks at full scale
    begin_run(2, 30000);
    feed(2, 30000, 2, 1'b0, 1'b0);
    collect(2, 30000, "R5");

    // R6: new run after large sums must not inherit them
    begin_run(4, 3);
    feed(4, 3, 3, 1'b0, 1'b0);
    collect(4, 3, "R6");

    // R9: single-position blocks
    begin_run(1, 4);
    feed(1, 4, 0, 1'b0, 1'b1);
    collect(1, 4, "R9");

    // R2 R8: longer block with gaps
    begin_run(37, 9);
    feed(37, 9, 0, 1'b0, 1'b1);
    collect(37, 9, "R8");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule